// File: doc/BRIEF.md
# Video Processor Control Register Slave

This block is the serial control port of a video processing device. A host on a two-wire I2C bus addresses it with a fixed 7-bit device address. Write transfers carry a register index followed by data bytes. Each data byte goes into the indexed register, and the index then advances, so one transfer can load a run of consecutive registers. Read transfers return two status bytes. The first carries a power-on flag and state reported by other blocks. The second carries more reported state and echoes the two crystal-selection bits the host last wrote.

After a reset the power-on flag reads 1. It stays at 1 until the host completes a read of the first status byte. The block also records which registers have been written since reset. Once every valid index has received a write, it raises a level output that other logic uses to begin its own start-up. Bus timing is recovered by oversampling SCL and SDA with the system clock. SDA is modelled as an open-drain pad with separate input, output and enable pins.

Top module: `vidcfg_i2c_slave`

## Requirements
- R1: An address byte equal to 0x8A (7-bit address 0x45, write) or 0x8B (read) is acknowledged. Any other address byte gets NACK, and the block ignores the bus until the next START.
- R2: In a write transfer, the first byte after the address is the register index. Each later byte is stored in the indexed register, which appears on `regs_o[8*i+7:8*i]` for index i.
- R3: The index increments by one after every stored data byte, so one transfer can fill several consecutive registers.
- R4: Data bytes sent to an index above 0x16, including the test index 0xFE, are acknowledged and leave every register unchanged.
- R5: A read transfer first returns status byte A = {power-on flag, `stat_a_i[6:0]`}. If the host ACKs, it next returns status byte B = {`stat_b_i[5:0]`, register 0x00 bits 1:0}. While the host keeps ACKing, A and B alternate. A NACK ends the transfer.
- R6: `por_o` is 1 after reset. It clears once the host has clocked the acknowledge slot following status byte A. Only a reset sets it again.
- R7: `cfg_done_o` rises once every index from 0x00 to 0x16 has been written at least once since reset. It then stays high until the next reset.
- R8: A STOP returns the block to idle, so bus activity without a new START has no effect. A repeated START begins a new address phase.
- R9: During and after reset, all registers are 0x00, `sda_oe_o` is 0 and `cfg_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_o | output | 1 | Pad output value (always low, open-drain) |
| sda_oe_o | output | 1 | Pad enable; 1 pulls SDA low |
| stat_a_i | input | 7 | Status bits 6:0 of status byte A |
| stat_b_i | input | 6 | Status bits 7:2 of status byte B |
| regs_o | output | 184 | All 23 configuration registers, index i at bits 8*i+7:8*i |
| por_o | output | 1 | Power-on flag |
| cfg_done_o | output | 1 | Every register written since reset |

## Verification
The assertions watch, on every cycle, for properties that hold at all times. The power-on flag never sets again without a reset. The completion output never falls. A START always releases SDA. A cycle with no write, or with a write to an out-of-range index, leaves the register outputs unchanged. The bench's scenarios are the only way to show the byte-level protocol itself. That covers the acknowledge pattern for matching and mismatching addresses, the index advancing across the valid range and beyond it, the contents and alternation of the status bytes, the moment the power-on flag clears, the point at which the completion output rises, and the restart behaviour after STOP and repeated START.

// File: rtl/vidcfg_pkg.sv
package vidcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;

endpackage

// File: rtl/vidcfg_i2c_edges.sv
module vidcfg_i2c_edges #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[SYNC_STAGES-1];
      sda_p    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/vidcfg_i2c_fsm.sv
module vidcfg_i2c_fsm
  import vidcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] tx_a,
  input  logic [7:0] tx_b,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       por_clr
);

  localparam int CNTW = 4;
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(7);
  localparam logic [CNTW-1:0] BYTE_LEN = CNTW'(8);

  bus_st_e        st;
  logic [CNTW-1:0] bitcnt;
  logic [7:0]     shreg;
  logic [7:0]     txsh;
  logic [7:0]     index;
  logic           rw;
  logic           first;
  logic           rd_sel;
  logic           host_ack;

  always_ff @(posedge clk) begin
    wr_en   <= 1'b0;
    por_clr <= 1'b0;
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      index    <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      rd_sel   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (start_ev) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == BYTE_LEN) begin
            if (st == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                first  <= 1'b1;
                st     <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_WR_ACK;
              first  <= 1'b0;
              if (first) begin
                index <= shreg;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= index;
                wr_data <= shreg;
                index   <= index + 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              txsh   <= tx_a;
              sda_oe <= ~tx_a[7];
              rd_sel <= 1'b0;
              st     <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_RD_ACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
            if (!rd_sel) por_clr <= 1'b1;
          end else if (scl_fall) begin
            if (host_ack) begin
              bitcnt <= '0;
              rd_sel <= ~rd_sel;
              txsh   <= rd_sel ? tx_a : tx_b;
              sda_oe <= rd_sel ? ~tx_a[7] : ~tx_b[7];
              st     <= ST_RD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vidcfg_regfile.sv
module vidcfg_regfile #(
  parameter int NREG = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat,
  output logic              all_seen
);

  localparam int IDXW = $clog2(NREG);
  localparam logic [7:0] TOP_IDX = 8'(NREG - 1);

  logic [7:0]      mem [NREG];
  logic [NREG-1:0] seen;
  logic            hit;

  assign hit = wr_en && (wr_addr <= TOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      seen     <= '0;
      all_seen <= 1'b0;
    end else begin
      if (hit) begin
        mem[wr_addr[IDXW-1:0]]  <= wr_data;
        seen[wr_addr[IDXW-1:0]] <= 1'b1;
      end
      all_seen <= &seen;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = mem[g];
  end

endmodule

// File: rtl/vidcfg_status.sv
module vidcfg_status #(
  parameter int A_BITS = 7,
  parameter int B_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_clr,
  input  logic [A_BITS-1:0] stat_a,
  input  logic [B_BITS-1:0] stat_b,
  input  logic [1:0]        xtal_sel,
  output logic              por_flag,
  output logic [7:0]        tx_a,
  output logic [7:0]        tx_b
);

  always_ff @(posedge clk) begin
    if (rst)          por_flag <= 1'b1;
    else if (por_clr) por_flag <= 1'b0;
  end

  assign tx_a = {por_flag, stat_a};
  assign tx_b = {stat_b, xtal_sel};

endmodule

// File: rtl/vidcfg_i2c_slave.sv
module vidcfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter int         LAST_SUB    = 22,
  parameter int         SYNC_STAGES = 2,
  localparam int        NREG        = LAST_SUB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic [6:0]        stat_a_i,
  input  logic [5:0]        stat_b_i,
  output logic [NREG*8-1:0] regs_o,
  output logic              por_o,
  output logic              cfg_done_o
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en, por_clr, por_flag;
  logic [7:0] wr_addr, wr_data, tx_a, tx_b;

  vidcfg_i2c_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  vidcfg_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_a(tx_a), .tx_b(tx_b), .sda_oe(sda_oe_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .por_clr(por_clr)
  );

  vidcfg_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(regs_o), .all_seen(cfg_done_o)
  );

  vidcfg_status #(.A_BITS(7), .B_BITS(6)) u_status (
    .clk(clk), .rst(rst), .por_clr(por_clr), .stat_a(stat_a_i),
    .stat_b(stat_b_i), .xtal_sel(regs_o[1:0]), .por_flag(por_flag),
    .tx_a(tx_a), .tx_b(tx_b)
  );

  assign sda_o = 1'b0;
  assign por_o = por_flag;

endmodule

// File: rtl/vidcfg_i2c_slave_chk.sv
module vidcfg_i2c_slave_chk #(
  parameter int NREG = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              por_o,
  input logic              cfg_done_o,
  input logic              sda_oe_o,
  input logic              start_ev,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [NREG*8-1:0] regs_o
);

  localparam logic [7:0] TOP_IDX = 8'(NREG - 1);

  a_r6_por_stays_clear: assert property (@(posedge clk) disable iff (rst)
    !por_o |=> !por_o);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_done_o |=> cfg_done_o);

  a_r8_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe_o);

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));

  a_r4_oor_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > TOP_IDX) |=> $stable(regs_o));

  a_r4_test_index_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'hFE) |=> $stable(regs_o));

endmodule

bind vidcfg_i2c_slave vidcfg_i2c_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .por_o(por_o), .cfg_done_o(cfg_done_o),
  .sda_oe_o(sda_oe_o), .start_ev(start_ev), .wr_en(wr_en),
  .wr_addr(wr_addr), .regs_o(regs_o)
);

// File: tb/vidcfg_i2c_slave_bench.sv
module vidcfg_i2c_slave_bench;

  localparam int NREG = 23;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [6:0] stat_a = '0;
  logic [5:0] stat_b = '0;
  logic sda_o, sda_oe, por, done_o;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_r [NREG];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  vidcfg_i2c_slave u_vidcfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe_o(sda_oe), .stat_a_i(stat_a), .stat_b_i(stat_b),
    .regs_o(regs), .por_o(por), .cfg_done_o(done_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(regs[i*8 +: 8]), 32'(exp_r[i]));
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_reset;
    rst = 1'b1; tick(5);
    rst = 1'b0; tick(2);
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * k + 7) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [NREG*8-1:0] snap;

    do_reset();
    // R9 reset state
    chk("R9 regs zero", 32'(regs == '0), 1);
    chk("R9 sda released", 32'(sda_oe), 0);
    chk("R9 done low", 32'(done_o), 0);
    chk("R6 por after reset", 32'(por), 1);

    // R1 mismatching address gets NACK and later bytes are ignored
    bus_start(); send_byte(8'h8C, ack);
    chk("R1 nack wrong addr", 32'(ack), 0);
    send_byte(8'h00, ack); send_byte(8'h55, ack); bus_stop();
    chk("R1 wrong addr no write", 32'(regs == '0), 1);

    // R2 R3 load indices 0x00..0x15 in one transfer
    bus_start(); send_byte(8'h8A, ack);
    chk("R1 ack write addr", 32'(ack), 1);
    send_byte(8'h00, ack);
    for (int i = 0; i < NREG - 1; i++) begin
      send_byte(pat(i, 29), ack);
      exp_r[i] = pat(i, 29);
      chk("R3 data ack", 32'(ack), 1);
    end
    bus_stop();
    chk("R7 done low with one index left", 32'(done_o), 0);
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h16, ack);
    send_byte(8'hC3, ack); exp_r[22] = 8'hC3; bus_stop();
    chk("R7 done after full load", 32'(done_o), 1);
    chk_regs("R2 register sweep");

    // R3 R4 increment past the last valid index
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h15, ack);
    send_byte(8'h3C, ack); exp_r[21] = 8'h3C;
    send_byte(8'h5A, ack); exp_r[22] = 8'h5A;
    send_byte(8'hEE, ack);
    chk("R4 ack beyond range", 32'(ack), 1);
    bus_stop();
    chk_regs("R3 R4 boundary run");

    // R4 test index 0xFE and a far index
    snap = regs;
    bus_start(); send_byte(8'h8A, ack); send_byte(8'hFE, ack);
    send_byte(8'h99, ack);
    chk("R4 ack at test index", 32'(ack), 1);
    bus_stop();
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h40, ack);
    send_byte(8'h12, ack); bus_stop();
    chk("R4 registers unchanged", 32'(regs == snap), 1);

    // R5 R6 status read with alternation
    stat_a = 7'h2A; stat_b = 6'h15;
    bus_start(); send_byte(8'h8B, ack);
    chk("R1 ack read addr", 32'(ack), 1);
    read_byte(1'b1, b);
    chk("R5 R6 byte A with flag", 32'(b), 32'({1'b1, 7'h2A}));
    read_byte(1'b1, b);
    chk("R5 byte B", 32'(b), 32'({6'h15, exp_r[0][1:0]}));
    read_byte(1'b0, b);
    chk("R5 R6 byte A after clear", 32'(b), 32'({1'b0, 7'h2A}));
    bus_stop();
    chk("R6 por cleared", 32'(por), 0);

    // R5 sweep over status patterns and crystal bits
    for (int k = 0; k < 8; k++) begin
      bus_start(); send_byte(8'h8A, ack); send_byte(8'h00, ack);
      send_byte(8'(k * 16 + (k & 3)), ack); bus_stop();
      exp_r[0] = 8'(k * 16 + (k & 3));
      stat_a = 7'(k * 17 + 1); stat_b = 6'(k * 9 + 2);
      bus_start(); send_byte(8'h8B, ack);
      read_byte(1'b1, b);
      chk("R5 sweep byte A", 32'(b), 32'({1'b0, 7'(k * 17 + 1)}));
      read_byte(1'b0, b);
      chk("R5 sweep byte B", 32'(b), 32'({6'(k * 9 + 2), 2'(k & 3)}));
      bus_stop();
    end

    // R8 repeated START turns a write into a read
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h03, ack);
    send_byte(8'hA5, ack); exp_r[3] = 8'hA5;
    bus_start(); send_byte(8'h8B, ack);
    chk("R8 ack after repeated start", 32'(ack), 1);
    read_byte(1'b0, b);
    chk("R8 read after repeated start", 32'(b), 32'({1'b0, stat_a}));
    bus_stop();
    chk_regs("R8 write before repeated start");

    // R8 traffic after STOP without START is ignored
    snap = regs;
    send_byte(8'h8A, ack);
    chk("R8 no ack while idle", 32'(ack), 0);
    send_byte(8'h04, ack); send_byte(8'h77, ack); bus_stop();
    chk("R8 idle traffic no effect", 32'(regs == snap), 1);

    // R6 R7 R9 a new reset restores start-up state
    do_reset();
    chk("R6 por set again", 32'(por), 1);
    chk("R7 done cleared", 32'(done_o), 0);
    chk("R9 regs cleared", 32'(regs == '0), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule